// File: doc/BRIEF.md
# SAR ADC Serial Frame Reader

This block is the clock-domain-side master for a successive-approximation converter that is reached over a three-wire serial link. It derives a mode-3 serial clock (idle high, data driven on the falling edge, sampled on the rising edge) from the system clock. The half period is set by the `HALF` parameter. With the default of 4 system clocks per half period and a 50 MHz system clock, the serial clock runs at 6.25 MHz, which stays under the 8 MHz ceiling.

Each frame has four parts:
- Chip select is held high with the serial clock high for at least one full serial period.
- Chip select then falls, which makes the converter sample its input.
- A 16-bit control word is shifted out MSB first while a 16-bit reply is shifted in.
- Chip select returns high.

The reply is decoded in one of two ways. In tagged mode it carries a 4-bit channel number ahead of a 12-bit result. In padded mode it carries one zero, the 12-bit result, and three zeros. Padded replies are checked for non-zero pad bits. The result is then right-aligned for 12-, 10- or 8-bit resolution. It is offered on a valid/ready output.

A new frame is launched only while `run` is high. The previous result must also have been taken, unless `drop_en` allows it to be overwritten.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset `cs_n` and `sclk` are high and `out_valid` is low.
- R2: While `cs_n` is low, `sclk` has a period of exactly 2*HALF system clocks, and each frame contains exactly 16 rising `sclk` edges.
- R3: `mosi` carries the `ctrl_word` captured at frame start, MSB first, and changes only at `cs_n` falling or `sclk` falling edges.
- R4: `miso` is sampled on each rising `sclk` edge, and the 16 samples form the reply word, first bit as bit 15.
- R5: `sclk` stays high whenever `cs_n` is high. Before every `cs_n` falling edge, `cs_n` and `sclk` have both been high for at least 2*HALF system clocks.
- R6: With `chan_id_mode`=1, `out_chan` is reply bits 15:12 and the 12-bit result is reply bits 11:0.
- R7: With `chan_id_mode`=0, `out_chan` is 0 and the 12-bit result is reply bits 14:3.
- R8: With `chan_id_mode`=0, `out_ferr` is 1 exactly when reply bit 15 or any of bits 2:0 is 1. With `chan_id_mode`=1, `out_ferr` is 0.
- R9: `res_sel` selects the alignment of the 12-bit result into `out_data`:
  - 1 gives a 10-bit sample: the result shifted right by 2, upper bits zero.
  - 2 gives an 8-bit sample: the result shifted right by 4, upper bits zero.
  - 0 or 3 gives the full 12-bit result.
- R10: `out_valid` stays high until a cycle with `out_ready` high. While `out_valid` is high and `drop_en` is low, no frame starts.
- R11: With `drop_en` high, frames continue while `out_valid` is high, and each completed frame replaces the held result with the newest one.
- R12: While `run` is low, no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Allow new frames to start |
| drop_en | input | 1 | Allow a held result to be overwritten |
| chan_id_mode | input | 1 | 1: tagged reply layout, 0: padded layout |
| res_sel | input | 2 | 0/3: 12-bit, 1: 10-bit, 2: 8-bit |
| ctrl_word | input | 16 | Control word sent in the next frame |
| miso | input | 1 | Serial data from the converter |
| out_ready | input | 1 | Downstream accepts the result |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data to the converter |
| out_valid | output | 1 | Result available |
| out_chan | output | 4 | Channel number (0 in padded layout) |
| out_data | output | 12 | Right-aligned sample |
| out_ferr | output | 1 | Pad-bit error in padded layout |

## Verification
The decoder is driven with replies in both layouts at every resolution code.

- Tagged replies with distinct channel tags and asymmetric bit patterns confirm the field split and the bit order.
- Padded replies with a set leading bit, and separately a set trailing bit, show that each pad position reaches the error flag independently while the sample stays intact.
- All-ones and single-LSB results show whether the resolution shifts drop the right bits.

Each control word is captured by a model of the converter and compared with what was sent, which exposes errors in launch timing and in the edge used for shifting. Held-result, drop and run-gating sequences tell stalled frames apart from overwritten ones.

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int HALF = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        drop_en,
  input  logic        chan_id_mode,
  input  logic [1:0]  res_sel,
  input  logic [15:0] ctrl_word,
  input  logic        miso,
  input  logic        out_ready,
  output logic        cs_n,
  output logic        sclk,
  output logic        mosi,
  output logic        out_valid,
  output logic [3:0]  out_chan,
  output logic [11:0] out_data,
  output logic        out_ferr
);
  localparam int GW = $clog2(2*HALF+1);
  localparam logic [GW-1:0] GUARD_N = GW'(2*HALF);
  localparam logic [GW-1:0] HALF_M1 = GW'(HALF-1);

  typedef enum logic [1:0] {S_GAP, S_SHIFT, S_TAIL} st_t;
  st_t st;
  logic [GW-1:0] tcnt;
  logic [3:0]  bcnt;
  logic [15:0] tx, rx;
  logic        mode_q;
  logic [1:0]  res_q;
  logic        launch, capture;

  assign launch  = (st == S_GAP) && (tcnt >= GUARD_N) && run && (!out_valid || drop_en);
  assign capture = (st == S_TAIL) && (tcnt == HALF_M1);
  assign mosi    = tx[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP; tcnt <= '0; bcnt <= '0; tx <= '0; rx <= '0;
      cs_n <= 1'b1; sclk <= 1'b1; mode_q <= 1'b0; res_q <= 2'd0;
    end else begin
      case (st)
        S_GAP: begin
          if (launch) begin
            cs_n <= 1'b0; tx <= ctrl_word; mode_q <= chan_id_mode; res_q <= res_sel;
            tcnt <= '0; bcnt <= '0; st <= S_SHIFT;
          end else if (tcnt < GUARD_N) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (tcnt == HALF_M1) begin
            tcnt <= '0;
            if (sclk) begin
              sclk <= 1'b0;
              if (bcnt != 4'd0) tx <= {tx[14:0], 1'b0};
            end else begin
              sclk <= 1'b1;
              rx   <= {rx[14:0], miso};
              bcnt <= bcnt + 1'b1;
              if (bcnt == 4'd15) st <= S_TAIL;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: begin
          if (capture) begin
            cs_n <= 1'b1; tcnt <= '0; st <= S_GAP;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      endcase
    end
  end

  logic [11:0] raw, aligned;
  logic [3:0]  chan_d;
  logic        ferr_d;
  assign raw    = mode_q ? rx[11:0] : rx[14:3];
  assign chan_d = mode_q ? rx[15:12] : 4'd0;
  assign ferr_d = !mode_q && (rx[15] || (|rx[2:0]));

  always_comb begin
    case (res_q)
      2'd1:    aligned = {2'b00, raw[11:2]};
      2'd2:    aligned = {4'b0000, raw[11:4]};
      default: aligned = raw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_chan <= '0; out_data <= '0; out_ferr <= 1'b0;
    end else if (capture) begin
      out_valid <= 1'b1; out_chan <= chan_d; out_data <= aligned; out_ferr <= ferr_d;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_frame_reader_chk.sv
module adc_frame_reader_chk #(
  parameter int HALF = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run,
  input logic       drop_en,
  input logic       cs_n,
  input logic       sclk,
  input logic       mosi,
  input logic       out_valid,
  input logic       out_ready,
  input logic [3:0] out_chan,
  input logic       out_ferr
);
  logic [15:0] gcnt;
  logic [5:0]  rises;
  logic        s_d, c_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt <= '0; rises <= '0; s_d <= 1'b1; c_d <= 1'b1;
    end else begin
      s_d <= sclk; c_d <= cs_n;
      if (cs_n && sclk) gcnt <= (gcnt == 16'hFFFF) ? gcnt : gcnt + 1'b1;
      else gcnt <= '0;
      if (c_d && !cs_n) rises <= '0;
      else if (!cs_n && sclk && !s_d) rises <= rises + 1'b1;
    end
  end

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> sclk);
  p_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gcnt >= 16'(2*HALF)));
  p_sixteen_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (rises == 6'd16));
  p_mosi_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !$fell(cs_n) && !$fell(sclk)) |-> $stable(mosi));
  p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  p_start_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(run) && ($past(!out_valid) || $past(drop_en))));
  p_ferr_padded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ferr) |-> (out_chan == 4'd0));
endmodule

bind adc_frame_reader adc_frame_reader_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .drop_en(drop_en), .cs_n(cs_n), .sclk(sclk),
  .mosi(mosi), .out_valid(out_valid), .out_ready(out_ready), .out_chan(out_chan),
  .out_ferr(out_ferr));

// File: tb/sim_adc_frame_reader.sv
module sim_adc_frame_reader;
  localparam int HALF = 4;
  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, drop_en = 1'b0, chan_id_mode = 1'b0;
  logic [1:0]  res_sel = 2'd0;
  logic [15:0] ctrl_word = 16'h0;
  logic miso = 1'b0, out_ready = 1'b0;
  logic cs_n, sclk, mosi, out_valid, out_ferr;
  logic [3:0]  out_chan;
  logic [11:0] out_data;

  always #10 clk = ~clk;

  adc_frame_reader #(.HALF(HALF)) u0 (.*);

  int checks = 0, fails = 0;
  logic [15:0] resp = 16'h0, cap = 16'h0;
  int fcnt = 0, rcnt = 0;

  always @(negedge cs_n) begin fcnt = 0; rcnt = 0; miso = resp[15]; end
  always @(negedge sclk) if (!cs_n) begin
    if (fcnt > 0) miso = resp[15 - fcnt];
    fcnt = fcnt + 1;
  end
  always @(posedge sclk) if (!cs_n) begin cap = {cap[14:0], mosi}; rcnt = rcnt + 1; end

  int frames = 0, gcur = 0, gmin = 1000, icur = 0, imin = 1000, imax = 0;
  logic pc = 1'b1, ps = 1'b1, first_rise = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pc && !cs_n) begin frames++; if (gcur < gmin) gmin = gcur; first_rise = 1'b1; icur = 0; end
      if (cs_n && sclk) gcur++; else gcur = 0;
      if (!cs_n) begin
        icur++;
        if (sclk && !ps) begin
          if (!first_rise) begin if (icur < imin) imin = icur; if (icur > imax) imax = icur; end
          first_rise = 1'b0; icur = 0;
        end
      end
    end
    pc = cs_n; ps = sclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (out_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic accept();
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk); out_ready = 1'b0;
  endtask

  // {ctrl, resp, mode, res, chan, data, ferr}
  localparam logic [51:0] VEC [9] = '{
    {16'hA5C3, 16'h3ABC, 1'b1, 2'd0, 4'h3, 12'hABC, 1'b0},
    {16'h1234, 16'hF123, 1'b1, 2'd1, 4'hF, 12'h048, 1'b0},
    {16'h8001, 16'h7FF0, 1'b1, 2'd2, 4'h7, 12'h0FF, 1'b0},
    {16'h5A5A, 16'h55E0, 1'b0, 2'd0, 4'h0, 12'hABC, 1'b0},
    {16'hC003, 16'hD5E0, 1'b0, 2'd0, 4'h0, 12'hABC, 1'b1},
    {16'h0FF0, 16'h55E1, 1'b0, 2'd0, 4'h0, 12'hABC, 1'b1},
    {16'h3C3C, 16'h7FF8, 1'b0, 2'd1, 4'h0, 12'h3FF, 1'b0},
    {16'hFFFF, 16'h0008, 1'b0, 2'd3, 4'h0, 12'h001, 1'b0},
    {16'h0000, 16'h0000, 1'b1, 2'd0, 4'h0, 12'h000, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit got;
    int f0;
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1, "R1 cs_n", cs_n, 1);
    chk(sclk === 1'b1, "R1 sclk", sclk, 1);
    chk(out_valid === 1'b0, "R1 out_valid", out_valid, 0);
    rst_n = 1'b1;
    repeat (300) @(negedge clk);
    chk(frames == 0, "R12 no frame while run low", frames, 0);

    for (int v = 0; v < 9; v++) begin
      ctrl_word = VEC[v][51:36]; resp = VEC[v][35:20];
      chan_id_mode = VEC[v][19]; res_sel = VEC[v][18:17];
      run = 1'b1;
      wait_valid(got);
      run = 1'b0;
      chk(got, "R10 result arrives", got, 1);
      chk(out_chan == VEC[v][16:13], "R6 R7 channel", out_chan, VEC[v][16:13]);
      chk(out_data == VEC[v][12:1], "R9 R4 data", out_data, VEC[v][12:1]);
      chk(out_ferr == VEC[v][0], "R8 ferr", out_ferr, VEC[v][0]);
      chk(cap == VEC[v][51:36], "R3 control word", cap, VEC[v][51:36]);
      chk(rcnt == 16, "R2 rising edges", rcnt, 16);
      accept();
    end

    // R10: held result blocks new frames
    ctrl_word = 16'h1111; resp = 16'h3ABC; chan_id_mode = 1'b1; res_sel = 2'd0; run = 1'b1;
    wait_valid(got);
    f0 = frames;
    repeat (400) @(negedge clk);
    chk(frames == f0, "R10 no frame while held", frames, f0);
    chk(out_valid && out_chan == 4'h3, "R10 result held", out_chan, 3);
    accept();
    repeat (200) @(negedge clk);
    chk(frames > f0, "R10 frame resumes after accept", frames, f0 + 1);

    // R11: drop enabled overwrites
    wait_valid(got);
    resp = 16'h5123; drop_en = 1'b1;
    f0 = frames;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (frames > f0 && cs_n) break;
    end
    repeat (3) @(negedge clk);
    run = 1'b0; drop_en = 1'b0;
    repeat (300) @(negedge clk);
    chk(out_valid === 1'b1, "R11 still valid", out_valid, 1);
    chk(out_chan == 4'h5 && out_data == 12'h123, "R11 newest result", {out_chan, out_data}, 16'h5123);
    accept();

    chk(imin == 2*HALF && imax == 2*HALF, "R2 sclk period", imin, 2*HALF);
    chk(gmin >= 2*HALF, "R5 guard before cs fall", gmin, 2*HALF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule